// File: doc/BRIEF.md
# Random-Number Peripheral Register Front-End

This block is the software-facing register window of a random-number peripheral. An external entropy source outside this block delivers 32-bit words with a valid strobe. It also reports a source-failure level and the result of health tests it runs on request. The block keeps the most recent word for software and reports whether it is ready. It shows the health state, the key state and a load count, and drives a single interrupt line.

Software can also request key generation. While key generation is requested, source words are diverted into a hidden 128-bit key register and never reach the data register. After four words the block raises a done flag and clears the request bit by itself. A wipe command zeroes the key. The bus side is a plain single-cycle port: a write takes effect at the clock edge that samples it, and read data is registered and valid one cycle after the request.

Top module: `rng_regfront`

## Requirements
- R1: After reset every register reads zero, `irq` and `test_start` are low, and the key output is zero. Registers sit at byte offsets 0x0 (control), 0x4 (status) and 0x8 (data). Read data appears on `bus_rdata` in the cycle after the request.
- R2: When ready is 0 and key generation is idle, a source word is captured and ready (status bit 0) becomes 1. A data read returns that word and clears ready at the same edge.
- R3: A data read returns 0x00000000 when ready is 0 or when `enable` is low.
- R4: A source word that arrives while ready is 1 is dropped, and the held word is unchanged.
- R5: `irq` is registered. It is high one cycle after (ready AND control bit 1) OR (health-fail AND control bit 2) holds.
- R6: Writing 1 to control bit 3 (user) or bit 4 (system) starts key generation. The next four source words fill the key, with the first word in key bits 31:0, and they do not set ready. On the fourth word, status bit 4 (key done) becomes 1 and both start bits clear.
- R7: Status bits 31:24 hold a load count that increments by one for each word loaded into the key.
- R8: Writing 1 to control bit 15 zeroes the key and the key-done bit on the following edge. Bit 15 then reads 0 again.
- R9: Writing 1 to control bit 0 while no test is running pulses `test_start` for exactly one cycle and sets status bit 1. Bit 1 stays set until `test_done`. A request made while a test is running is ignored.
- R10: On `test_done` during a test, status bit 2 latches the inverse of `test_pass` (1 = failed).
- R11: Status bit 3 shows `src_fail` with one register of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Peripheral enable; gates data reads |
| bus_sel | input | 1 | Bus request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| src_valid | input | 1 | Source word strobe |
| src_word | input | 32 | Source random word |
| src_fail | input | 1 | Entropy source failure level |
| test_start | output | 1 | One-cycle health-test request |
| test_done | input | 1 | Health test finished |
| test_pass | input | 1 | Health test result, valid with test_done |
| key_out | output | 128 | Secure key register contents |
| key_ready | output | 1 | Key fully loaded |
| irq | output | 1 | Interrupt |

## Verification
On every cycle the assertions check several invariants. A data read while ready is 0 returns zero. Ready holds until a data read. Key generation never raises ready. A wipe clears the key on the next edge. The test-start strobe lasts a single cycle. The interrupt follows its enabled sources. Each key load advances the count by one. The bench scenarios are needed for the data values themselves: the word a read returns, word dropping under a random mix of pushes and reads with `enable` toggling, key word placement, the auto-clear of the start bits, and the latched pass/fail result.

// File: rtl/rng_pkg.sv
package rng_pkg;
  localparam int unsigned WORD_W = 32;

  localparam int unsigned OFS_CTRL = 'h0;
  localparam int unsigned OFS_STAT = 'h4;
  localparam int unsigned OFS_DATA = 'h8;

  localparam int unsigned CB_TEST   = 0;
  localparam int unsigned CB_IE_RDY = 1;
  localparam int unsigned CB_IE_HT  = 2;
  localparam int unsigned CB_KG_USR = 3;
  localparam int unsigned CB_KG_SYS = 4;
  localparam int unsigned CB_WIPE   = 15;

  localparam int unsigned SB_RDY   = 0;
  localparam int unsigned SB_TEST  = 1;
  localparam int unsigned SB_HT    = 2;
  localparam int unsigned SB_SRCF  = 3;
  localparam int unsigned SB_KDONE = 4;
  localparam int unsigned SB_CNT   = 24;

  typedef struct packed {
    logic ie_rdy;
    logic ie_ht;
    logic kg_usr;
    logic kg_sys;
    logic wipe;
  } ctrl_t;
endpackage

// File: rtl/rng_ctrl_regs.sv
module rng_ctrl_regs
  import rng_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_ctrl,
  input  logic [WORD_W-1:0] wdata,
  input  logic              kg_finish,
  output ctrl_t             ctrl
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= '0;
    end else begin
      ctrl.wipe <= 1'b0;
      if (kg_finish) begin
        ctrl.kg_usr <= 1'b0;
        ctrl.kg_sys <= 1'b0;
      end
      if (wr_ctrl) begin
        ctrl.ie_rdy <= wdata[CB_IE_RDY];
        ctrl.ie_ht  <= wdata[CB_IE_HT];
        if (wdata[CB_KG_USR]) ctrl.kg_usr <= 1'b1;
        if (wdata[CB_KG_SYS]) ctrl.kg_sys <= 1'b1;
        if (wdata[CB_WIPE])   ctrl.wipe   <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/rng_word_buffer.sv
module rng_word_buffer #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cap_en,
  input  logic         src_valid,
  input  logic [W-1:0] src_word,
  input  logic         take,
  output logic         rdy,
  output logic [W-1:0] word
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rdy  <= 1'b0;
      word <= '0;
    end else if (rdy) begin
      if (take) rdy <= 1'b0;
    end else if (cap_en && src_valid) begin
      rdy  <= 1'b1;
      word <= src_word;
    end
  end
endmodule

// File: rtl/rng_key_store.sv
module rng_key_store #(
  parameter int unsigned W         = 32,
  parameter int unsigned KEY_WORDS = 4,
  parameter int unsigned CNT_W     = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   active,
  input  logic                   src_valid,
  input  logic [W-1:0]           src_word,
  input  logic                   wipe,
  output logic [KEY_WORDS*W-1:0] key,
  output logic                   kdone,
  output logic                   finish,
  output logic [CNT_W-1:0]       ld_cnt
);
  localparam int unsigned IDX_W = (KEY_WORDS > 1) ? $clog2(KEY_WORDS) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(KEY_WORDS - 1);

  logic [IDX_W-1:0] idx;
  logic [W-1:0]     slot [KEY_WORDS];
  logic             load;

  assign load   = active && src_valid && !wipe;
  assign finish = load && (idx == LAST);

  for (genvar g = 0; g < KEY_WORDS; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst || wipe) slot[g] <= '0;
      else if (load && idx == IDX_W'(g)) slot[g] <= src_word;
    end
    assign key[g*W +: W] = slot[g];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx    <= '0;
      kdone  <= 1'b0;
      ld_cnt <= '0;
    end else if (wipe) begin
      idx   <= '0;
      kdone <= 1'b0;
    end else if (load) begin
      ld_cnt <= ld_cnt + 1'b1;
      idx    <= finish ? '0 : idx + 1'b1;
      if (finish) kdone <= 1'b1;
    end
  end
endmodule

// File: rtl/rng_health_seq.sv
module rng_health_seq (
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic test_done,
  input  logic test_pass,
  output logic test_start,
  output logic busy,
  output logic ht_fail
);
  always_ff @(posedge clk) begin
    if (rst) begin
      test_start <= 1'b0;
      busy       <= 1'b0;
      ht_fail    <= 1'b0;
    end else begin
      test_start <= req && !busy;
      if (busy && test_done) begin
        busy    <= 1'b0;
        ht_fail <= !test_pass;
      end else if (req) begin
        busy <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/rng_regfront.sv
module rng_regfront
  import rng_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned KEY_WORDS = 4,
  parameter int unsigned CNT_W     = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        enable,
  input  logic                        bus_sel,
  input  logic                        bus_wr,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [WORD_W-1:0]           bus_wdata,
  output logic [WORD_W-1:0]           bus_rdata,
  input  logic                        src_valid,
  input  logic [WORD_W-1:0]           src_word,
  input  logic                        src_fail,
  output logic                        test_start,
  input  logic                        test_done,
  input  logic                        test_pass,
  output logic [KEY_WORDS*WORD_W-1:0] key_out,
  output logic                        key_ready,
  output logic                        irq
);
  logic hit_ctrl, hit_stat, hit_data;
  logic wr_ctrl, rd_data;
  ctrl_t ctrl;
  logic kg_active, kg_finish;
  logic rdy;
  logic [WORD_W-1:0] held;
  logic [CNT_W-1:0]  ld_cnt;
  logic test_busy, ht_fail, srcf_q;
  logic [WORD_W-1:0] ctrl_view, stat_view, rd_next;

  assign hit_ctrl = bus_addr == ADDR_W'(OFS_CTRL);
  assign hit_stat = bus_addr == ADDR_W'(OFS_STAT);
  assign hit_data = bus_addr == ADDR_W'(OFS_DATA);
  assign wr_ctrl  = bus_sel && bus_wr && hit_ctrl;
  assign rd_data  = bus_sel && !bus_wr && hit_data;
  assign kg_active = ctrl.kg_usr || ctrl.kg_sys;

  rng_ctrl_regs u_ctrl (
    .clk(clk), .rst(rst), .wr_ctrl(wr_ctrl), .wdata(bus_wdata),
    .kg_finish(kg_finish), .ctrl(ctrl)
  );

  rng_word_buffer #(.W(WORD_W)) u_buf (
    .clk(clk), .rst(rst), .cap_en(!kg_active), .src_valid(src_valid),
    .src_word(src_word), .take(rd_data), .rdy(rdy), .word(held)
  );

  rng_key_store #(.W(WORD_W), .KEY_WORDS(KEY_WORDS), .CNT_W(CNT_W)) u_key (
    .clk(clk), .rst(rst), .active(kg_active), .src_valid(src_valid),
    .src_word(src_word), .wipe(ctrl.wipe), .key(key_out), .kdone(key_ready),
    .finish(kg_finish), .ld_cnt(ld_cnt)
  );

  rng_health_seq u_health (
    .clk(clk), .rst(rst), .req(wr_ctrl && bus_wdata[CB_TEST]),
    .test_done(test_done), .test_pass(test_pass),
    .test_start(test_start), .busy(test_busy), .ht_fail(ht_fail)
  );

  always_comb begin
    ctrl_view = '0;
    ctrl_view[CB_IE_RDY] = ctrl.ie_rdy;
    ctrl_view[CB_IE_HT]  = ctrl.ie_ht;
    ctrl_view[CB_KG_USR] = ctrl.kg_usr;
    ctrl_view[CB_KG_SYS] = ctrl.kg_sys;
    ctrl_view[CB_WIPE]   = ctrl.wipe;
    stat_view = '0;
    stat_view[SB_RDY]   = rdy;
    stat_view[SB_TEST]  = test_busy;
    stat_view[SB_HT]    = ht_fail;
    stat_view[SB_SRCF]  = srcf_q;
    stat_view[SB_KDONE] = key_ready;
    stat_view[SB_CNT +: CNT_W] = ld_cnt;
    rd_next = '0;
    if (hit_ctrl)      rd_next = ctrl_view;
    else if (hit_stat) rd_next = stat_view;
    else if (hit_data) rd_next = (rdy && enable) ? held : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      srcf_q    <= 1'b0;
      irq       <= 1'b0;
    end else begin
      if (bus_sel && !bus_wr) bus_rdata <= rd_next;
      srcf_q <= src_fail;
      irq    <= (rdy && ctrl.ie_rdy) || (ht_fail && ctrl.ie_ht);
    end
  end
endmodule

// File: rtl/rng_regfront_chk.sv
module rng_regfront_chk #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned KEYW   = 128,
  parameter int unsigned CNT_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_rdata,
  input logic              src_valid,
  input logic              rdy,
  input logic              kg_active,
  input logic              wipe,
  input logic [KEYW-1:0]   key_out,
  input logic              key_ready,
  input logic              test_start,
  input logic              ie_rdy,
  input logic              irq,
  input logic [CNT_W-1:0]  ld_cnt
);
  logic rd_data;
  assign rd_data = bus_sel && !bus_wr && bus_addr == ADDR_W'(8);

  // R3
  empty_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rd_data && !rdy |=> bus_rdata == '0);
  // R4
  ready_hold_chk: assert property (@(posedge clk) disable iff (rst)
    rdy && !rd_data |=> rdy);
  // R6
  kg_no_ready_chk: assert property (@(posedge clk) disable iff (rst)
    kg_active && !rdy |=> !rdy);
  // R8
  wipe_clear_chk: assert property (@(posedge clk) disable iff (rst)
    wipe |=> key_out == '0 && !key_ready);
  // R9
  start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    test_start |=> !test_start);
  // R5
  irq_ready_chk: assert property (@(posedge clk) disable iff (rst)
    rdy && ie_rdy |=> irq);
  // R7
  load_count_chk: assert property (@(posedge clk) disable iff (rst)
    kg_active && src_valid && !wipe |=> ld_cnt == $past(ld_cnt) + 1'b1);
endmodule

bind rng_regfront rng_regfront_chk #(
  .ADDR_W(ADDR_W), .KEYW(KEY_WORDS*32), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .src_valid(src_valid),
  .rdy(rdy), .kg_active(kg_active), .wipe(ctrl.wipe), .key_out(key_out),
  .key_ready(key_ready), .test_start(test_start), .ie_rdy(ctrl.ie_rdy),
  .irq(irq), .ld_cnt(ld_cnt)
);

// File: tb/tb_rng_regfront.sv
module tb_rng_regfront;
  logic clk = 1'b0, rst = 1'b1, enable = 1'b1;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic src_valid = 1'b0, src_fail = 1'b0, test_done = 1'b0, test_pass = 1'b0;
  logic [31:0] src_word = '0;
  logic test_start, key_ready, irq;
  logic [127:0] key_out;

  int total = 0, bad = 0, starts = 0;

  rng_regfront dut (.*);

  always #5 clk = ~clk;
  always @(posedge clk) if (test_start) starts++;

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk); bus_sel = 0; d = bus_rdata;
  endtask

  task automatic push(input logic [31:0] w);
    @(negedge clk); src_valid = 1; src_word = w;
    @(negedge clk); src_valid = 0;
  endtask

  function automatic logic [31:0] exp_data(input bit r, input bit en, input logic [31:0] w);
    return (r && en) ? w : 32'h0;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    bit m_rdy;
    logic [31:0] m_word;
    logic [127:0] m_key;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    rd(12'h0, v); check("R1 ctrl", v, 0);
    rd(12'h4, v); check("R1 status", v, 0);
    rd(12'h8, v); check("R1 data", v, 0);
    check("R1 irq", irq, 0);
    check("R1 key", key_out, 0);

    // R2/R3/R4 random mix
    m_rdy = 0; m_word = 0;
    for (int i = 0; i < 400; i++) begin
      int op;
      op = $urandom_range(0, 3);
      enable = $urandom_range(0, 3) != 0;
      if (op == 0 || op == 1) begin
        logic [31:0] w;
        w = $urandom();
        push(w);
        if (!m_rdy) begin m_rdy = 1; m_word = w; end
      end else if (op == 2) begin
        rd(12'h8, v);
        check("R2/R3/R4 data read", v, exp_data(m_rdy, enable, m_word));
        m_rdy = 0;
      end else begin
        rd(12'h4, v);
        check("R2 status ready", v, {31'h0, m_rdy});
      end
    end
    enable = 1;
    // R3 read while not ready
    if (m_rdy) rd(12'h8, v);
    rd(12'h8, v); check("R3 empty read", v, 0);
    // R4 second word dropped
    push(32'hAAAA_0001); push(32'hBBBB_0002);
    rd(12'h8, v); check("R4 first word kept", v, 32'hAAAA_0001);
    // R5 ready interrupt
    wr(12'h0, 32'h2);
    push(32'h1234_5678);
    @(negedge clk); check("R5 irq ready", irq, 1);
    rd(12'h8, v); check("R2 word", v, 32'h1234_5678);
    @(negedge clk); check("R5 irq cleared", irq, 0);

    // R6/R7 key generation
    wr(12'h0, 32'h8);
    m_key = 0;
    for (int k = 0; k < 4; k++) begin
      logic [31:0] w;
      w = $urandom();
      m_key[k*32 +: 32] = w;
      push(w);
      if (k == 1) begin rd(12'h4, v); check("R6 ready stays 0", v[0], 0); end
    end
    check("R6 key value", key_out, m_key);
    check("R6 key_ready", key_ready, 1);
    rd(12'h0, v); check("R6 start bit cleared", v[3], 0);
    rd(12'h4, v); check("R6/R7 status", v, 32'h0400_0010);
    rd(12'h8, v); check("R6 words hidden", v, 0);
    wr(12'h0, 32'h10);
    for (int k = 0; k < 4; k++) push(32'h100 + k);
    rd(12'h0, v); check("R6 system bit cleared", v[4], 0);
    rd(12'h4, v); check("R7 count 8", v[31:24], 8'd8);

    // R8 wipe
    wr(12'h0, 32'h8000);
    @(negedge clk);
    check("R8 key zero", key_out, 0);
    rd(12'h4, v); check("R8 done cleared", v[4], 0);
    rd(12'h0, v); check("R8 wipe self-clear", v[15], 0);

    // R9/R10 health test
    starts = 0;
    wr(12'h0, 32'h5);
    rd(12'h4, v); check("R9 busy", v[1], 1);
    wr(12'h0, 32'h5);
    check("R9 one pulse", starts, 1);
    @(negedge clk); test_done = 1; test_pass = 0;
    @(negedge clk); test_done = 0;
    rd(12'h4, v); check("R10 fail latched", v[2:1], 2'b10);
    check("R5 health irq", irq, 1);
    wr(12'h0, 32'h1);
    @(negedge clk); test_done = 1; test_pass = 1;
    @(negedge clk); test_done = 0;
    rd(12'h4, v); check("R10 pass latched", v[2:1], 2'b00);
    check("R9 two pulses", starts, 2);

    // R11 source failure
    @(negedge clk); src_fail = 1;
    @(negedge clk);
    rd(12'h4, v); check("R11 srcfail", v[3], 1);
    src_fail = 0;
    @(negedge clk);
    rd(12'h4, v); check("R11 srcfail low", v[3], 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule